// File: doc/BRIEF.md
# Three-Channel Residue-to-Binary Converter

This block turns a number held as three residues back into its ordinary binary form. The three moduli come from one parameter N: 2^N−1, 2^N and 2^N+1. They are pairwise coprime, so together they cover the range 0 to M−1, where M is their product. The block follows the Chinese Remainder Theorem. Each channel multiplies its residue by the inverse of its cofactor and reduces the result within its own modulus. It then scales the result by the cofactor M/m_i, which gives a term already below M. The three terms are added and folded back under M by a short chain of conditional subtractions.

All three channels work at the same time in the first pipeline stage. The sum and fold form the second stage, so a result appears two cycles after its residues. The block accepts one conversion per cycle. Its typical use is at the back end of a residue-arithmetic datapath, where sums and products have been formed carry-free in each channel and must be brought back to binary.

Top module: `rns_crt_decoder`

## Requirements
- R1: With res_lo = X mod (2^N−1), res_mid = X mod 2^N and res_hi = X mod (2^N+1) (res_hi is N+1 bits wide), value returns the unique X in [0, M−1], where M = (2^N−1)·2^N·(2^N+1); for the default N=8, M = 16776960.
- R2: Residues sampled with in_valid at one rising edge give their result on value, with out_valid high, after the second rising edge that follows; after the first of those edges out_valid is still low.
- R3: out_valid copies in_valid delayed by two cycles, so inputs on consecutive cycles give results on consecutive cycles, in the same order.
- R4: Whenever out_valid is high, value is below M.
- R5: While out_valid is low, value keeps its previous contents, whatever the residue inputs do.
- R6: While rst_n is low, out_valid and value are 0, and inputs offered during reset never produce a result after reset is released.
- R7: The range ends convert exactly: all-zero residues give 0, and the residues of M−1 give M−1; the same holds for X equal to 2^N−1, 2^N and 2^N+1.
- R8: With N=2 (moduli 3, 4 and 5, M = 60), every X from 0 to 59 converts back to itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Residues on this cycle are to be converted |
| res_lo | input | N | Residue modulo 2^N−1 |
| res_mid | input | N | Residue modulo 2^N |
| res_hi | input | N+1 | Residue modulo 2^N+1 |
| out_valid | output | 1 | value holds a fresh result this cycle |
| value | output | 3N | Reconstructed binary number |

## Verification
The in-module properties watch four things on every cycle: the two-cycle lag of the valid flag, the bound of every channel term and of the final value below M, the hold of value while no result is flagged, and the zero-in, zero-out path. None of them can tell whether a nonzero result is the right number. The directed scenarios show that: they compute residues with the remainder operator and expect the original integer back. They do this for a full sweep of the small configuration, for random and extreme values of the default one, and for back-to-back streams in which ordering and throughput are visible.

// File: rtl/rns_crt_pkg.sv
package rns_crt_pkg;

   localparam int unsigned CHANNELS = 3;

   // modulus of channel idx: 0 -> 2^n-1, 1 -> 2^n, 2 -> 2^n+1
   function automatic longint unsigned chan_modulus(int unsigned n, int unsigned idx);
      longint unsigned p;
      p = 64'(1) << n;
      case (idx)
         0:       return p - 64'(1);
         1:       return p;
         default: return p + 64'(1);
      endcase
   endfunction

   function automatic longint unsigned dyn_range(int unsigned n);
      return chan_modulus(n, 0) * chan_modulus(n, 1) * chan_modulus(n, 2);
   endfunction

   function automatic longint unsigned cofactor(int unsigned n, int unsigned idx);
      return dyn_range(n) / chan_modulus(n, idx);
   endfunction

   // closed-form inverse of the cofactor within its own modulus
   function automatic longint unsigned cof_inverse(int unsigned n, int unsigned idx);
      longint unsigned h;
      h = 64'(1) << (n - 1);
      case (idx)
         0:       return h;
         1:       return (64'(1) << n) - 64'(1);
         default: return h + 64'(1);
      endcase
   endfunction

endpackage

// File: rtl/rns_crt_channel.sv
module rns_crt_channel #(
   parameter int unsigned      RW      = 9,
   parameter int unsigned      VW      = 24,
   parameter longint unsigned  MOD     = 255,
   parameter longint unsigned  INV     = 128,
   parameter longint unsigned  COF     = 65792,
   parameter longint unsigned  M_RANGE = 16776960
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [RW-1:0] residue,
   output logic [VW-1:0] term
);

   if ((COF * INV) % MOD != 64'(1)) begin : g_bad_inverse
      $error("rns_crt_channel: weight inverse does not hold for this modulus");
   end
   if (COF * MOD != M_RANGE) begin : g_bad_cofactor
      $error("rns_crt_channel: cofactor times modulus differs from range");
   end

   logic [63:0]   prod;
   logic [63:0]   digit;
   logic [63:0]   scaled;
   logic [VW-1:0] term_next;

   always_comb begin
      prod      = 64'(residue) * INV;
      digit     = prod % MOD;
      scaled    = digit * COF;
      term_next = scaled[VW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     term <= '0;
      else if (load)  term <= term_next;
   end

   // each scaled term stays below the dynamic range (feeds R4)
   p_term_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      64'(term) < M_RANGE);

endmodule

// File: rtl/rns_crt_fold.sv
module rns_crt_fold #(
   parameter int unsigned     CH      = 3,
   parameter int unsigned     VW      = 24,
   parameter longint unsigned M_RANGE = 16776960
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [CH-1:0][VW-1:0]  terms,
   output logic [VW-1:0]          folded
);

   localparam int unsigned SW = VW + $clog2(CH);

   if (CH < 1) begin : g_bad_count
      $error("rns_crt_fold: channel count must be positive");
   end

   logic [SW-1:0] acc;
   logic [VW-1:0] fold_next;

   always_comb begin
      acc = '0;
      for (int i = 0; i < int'(CH); i++) acc = acc + SW'(terms[i]);
      for (int k = 0; k < int'(CH) - 1; k++) begin
         if (acc >= SW'(M_RANGE)) acc = acc - SW'(M_RANGE);
      end
      fold_next = acc[VW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     folded <= '0;
      else if (load)  folded <= fold_next;
   end

endmodule

// File: rtl/rns_crt_decoder.sv
module rns_crt_decoder #(
   parameter int unsigned N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   res_lo,
   input  logic [N-1:0]   res_mid,
   input  logic [N:0]     res_hi,
   output logic           out_valid,
   output logic [3*N-1:0] value
);
   import rns_crt_pkg::*;

   localparam int unsigned     VW      = 3 * N;
   localparam int unsigned     RW      = N + 1;
   localparam longint unsigned M_RANGE = dyn_range(N);

   if (N < 2 || N > 16) begin : g_bad_width
      $error("rns_crt_decoder: N must lie between 2 and 16");
   end

   logic [CHANNELS-1:0][RW-1:0] ch_res;
   logic [CHANNELS-1:0][VW-1:0] ch_term;
   logic                        s1_valid;

   assign ch_res[0] = {1'b0, res_lo};
   assign ch_res[1] = {1'b0, res_mid};
   assign ch_res[2] = res_hi;

   for (genvar i = 0; i < int'(CHANNELS); i++) begin : g_chan
      rns_crt_channel #(
         .RW      (RW),
         .VW      (VW),
         .MOD     (chan_modulus(N, i)),
         .INV     (cof_inverse(N, i)),
         .COF     (cofactor(N, i)),
         .M_RANGE (M_RANGE)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (in_valid),
         .residue (ch_res[i]),
         .term    (ch_term[i])
      );
   end

   rns_crt_fold #(
      .CH      (CHANNELS),
      .VW      (VW),
      .M_RANGE (M_RANGE)
   ) u_fold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (s1_valid),
      .terms  (ch_term),
      .folded (value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_valid  <= in_valid;
         out_valid <= s1_valid;
      end
   end

   p_valid_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)));

   p_value_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (64'(value) < M_RANGE));

   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(value));

   p_zero_maps_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && res_lo == '0 && res_mid == '0 && res_hi == '0) |-> ##2 (value == '0));

endmodule

// File: tb/rns_crt_decoder_bench.sv
module rns_crt_decoder_bench;

   localparam int unsigned     NB = 8;
   localparam int unsigned     NS = 2;
   localparam longint unsigned MB = 64'd16776960;
   localparam longint unsigned MS = 64'd60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic              b_valid = 1'b0;
   logic [NB-1:0]     b_lo = '0;
   logic [NB-1:0]     b_mid = '0;
   logic [NB:0]       b_hi = '0;
   logic              b_ovalid;
   logic [3*NB-1:0]   b_value;

   logic              s_valid = 1'b0;
   logic [NS-1:0]     s_lo = '0;
   logic [NS-1:0]     s_mid = '0;
   logic [NS:0]       s_hi = '0;
   logic              s_ovalid;
   logic [3*NS-1:0]   s_value;

   int checks = 0;
   int failures = 0;
   longint unsigned last_big = 0;
   longint unsigned xs [0:255];

   rns_crt_decoder #(.N(NB)) u_rns_crt_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(b_valid),
      .res_lo(b_lo), .res_mid(b_mid), .res_hi(b_hi),
      .out_valid(b_ovalid), .value(b_value));

   rns_crt_decoder #(.N(NS)) u_rns_crt_decoder_small (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid),
      .res_lo(s_lo), .res_mid(s_mid), .res_hi(s_hi),
      .out_valid(s_ovalid), .value(s_value));

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive_big(input bit v, input longint unsigned x);
      b_valid = v;
      b_lo    = NB'(x % 64'd255);
      b_mid   = NB'(x % 64'd256);
      b_hi    = (NB+1)'(x % 64'd257);
   endtask

   task automatic drive_small(input bit v, input longint unsigned x);
      s_valid = v;
      s_lo    = NS'(x % 64'd3);
      s_mid   = NS'(x % 64'd4);
      s_hi    = (NS+1)'(x % 64'd5);
   endtask

   // R6: reset clears outputs and swallows inputs offered meanwhile
   task automatic t_reset();
      @(negedge clk);
      drive_big(1'b1, 64'd12345);
      drive_small(1'b1, 64'd17);
      repeat (3) @(negedge clk);
      chk(b_ovalid == 1'b0, "R6 out_valid in reset", 64'(b_ovalid), 0);
      chk(b_value == '0, "R6 value in reset", 64'(b_value), 0);
      drive_big(1'b0, 64'd0);
      drive_small(1'b0, 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(b_ovalid == 1'b0, "R6 no result after release", 64'(b_ovalid), 0);
         chk(s_ovalid == 1'b0, "R6 small no result after release", 64'(s_ovalid), 0);
      end
   endtask

   // R2: exact two-cycle latency
   task automatic t_latency();
      @(negedge clk);
      drive_big(1'b1, 64'd9876543);
      @(negedge clk);
      drive_big(1'b0, 64'd0);
      chk(b_ovalid == 1'b0, "R2 not yet after one edge", 64'(b_ovalid), 0);
      @(negedge clk);
      chk(b_ovalid == 1'b1, "R2 valid after two edges", 64'(b_ovalid), 1);
      chk(64'(b_value) == 64'd9876543, "R2 value after two edges", 64'(b_value), 64'd9876543);
      @(negedge clk);
      chk(b_ovalid == 1'b0, "R2 single pulse", 64'(b_ovalid), 0);
      last_big = 64'd9876543;
   endtask

   // R1, R3, R4: random back-to-back stream
   task automatic t_stream();
      for (int i = 0; i < 200; i++) xs[i] = 64'($urandom) % MB;
      for (int j = 0; j < 202; j++) begin
         @(negedge clk);
         if (j >= 2) begin
            chk(b_ovalid == 1'b1, "R3 consecutive valid", 64'(b_ovalid), 1);
            chk(64'(b_value) == xs[j-2], "R1 random round trip", 64'(b_value), xs[j-2]);
            chk(64'(b_value) < MB, "R4 below range", 64'(b_value), MB - 1);
         end
         if (j < 200) drive_big(1'b1, xs[j]);
         else         drive_big(1'b0, 64'd0);
      end
      last_big = xs[199];
      @(negedge clk);
      chk(b_ovalid == 1'b0, "R3 valid drops after stream", 64'(b_ovalid), 0);
   endtask

   // R7: range ends and powers-of-two neighbours
   task automatic t_extremes();
      longint unsigned ev [0:6];
      ev[0] = 0; ev[1] = MB - 1; ev[2] = 1; ev[3] = 255;
      ev[4] = 256; ev[5] = 257; ev[6] = MB / 2;
      for (int j = 0; j < 9; j++) begin
         @(negedge clk);
         if (j >= 2) begin
            chk(64'(b_value) == ev[j-2], "R7 extreme round trip", 64'(b_value), ev[j-2]);
            chk(64'(b_value) < MB, "R4 extreme below range", 64'(b_value), MB - 1);
         end
         if (j < 7) drive_big(1'b1, ev[j]);
         else       drive_big(1'b0, 64'd0);
      end
      last_big = ev[6];
   endtask

   // R5: idle inputs wiggle, value holds
   task automatic t_hold();
      for (int j = 0; j < 6; j++) begin
         @(negedge clk);
         drive_big(1'b0, 64'($urandom) % MB);
         chk(b_ovalid == 1'b0, "R5 idle no valid", 64'(b_ovalid), 0);
         chk(64'(b_value) == last_big, "R5 value held", 64'(b_value), last_big);
      end
      drive_big(1'b0, 64'd0);
   endtask

   // R8: full sweep of the N=2 configuration
   task automatic t_small_sweep();
      for (int j = 0; j < int'(MS) + 2; j++) begin
         @(negedge clk);
         if (j >= 2) begin
            chk(s_ovalid == 1'b1, "R8 small valid", 64'(s_ovalid), 1);
            chk(64'(s_value) == 64'(j - 2), "R8 small round trip", 64'(s_value), 64'(j - 2));
         end
         if (j < int'(MS)) drive_small(1'b1, 64'(j));
         else              drive_small(1'b0, 64'd0);
      end
   endtask

   initial begin
      t_reset();
      t_latency();
      t_stream();
      t_extremes();
      t_hold();
      t_small_sweep();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule